// File: doc/BRIEF.md
# Passive Serial Configuration Loader

This block sits on the host side of a volatile programmable device and pushes the device's configuration image into it over a two-wire passive serial link: a shift clock and a single data line. Image bytes come from a local stream with valid/ready handshaking. The loader drives the device's active-low configuration-request line. It watches the device's active-low status line, its configuration-complete line and, when enabled, its initialization-complete line.

An attempt opens with a low pulse on the configuration request. The loader then waits for the status line to read high and shifts each byte out least significant bit first, one bit per shift-clock period. After the last byte it checks that the device reports configuration complete. It then issues a fixed number of extra shift clocks so the device can initialize, and it can also wait for the initialization-complete input. If the device reports an error, or configuration is not complete after the last bit, the loader pulses `rewind` so the image source restarts from its first byte, and it begins a new attempt. Once the retries are used up it raises a sticky error and goes idle until the next start request.

The half-period of the shift clock is set at run time through `half_div` and equals `half_div + 1` system clock cycles.

Top module: `ps_cfg_loader`

## Requirements
- R1: Out of reset, `tgt_cfg_n` is high, and `tgt_dclk`, `tgt_data`, `in_ready`, `busy`, `done`, `err` and `rewind` are all low.
- R2: A `start` pulse while not busy drives `tgt_cfg_n` low for exactly PULSE_CYC clock cycles, then releases it high. `start` is ignored while `busy` is high.
- R3: After `tgt_cfg_n` is released, no shift-clock rising edge occurs and `in_ready` stays low until `tgt_status_n` reads high.
- R4: Each byte goes out least significant bit first. The bit is placed on `tgt_data` while `tgt_dclk` is low, and `tgt_data` stays stable for the whole high phase of `tgt_dclk`.
- R5: Both the low phase and the high phase of each shift-clock period last `half_div + 1` clock cycles.
- R6: `in_ready` is high only when the loader is waiting for a byte and `tgt_status_n` is high. A byte is taken when `in_valid` and `in_ready` are both high at a clock edge, and `in_ready` is low in the next cycle.
- R7: If `tgt_conf_done` is low one half-period after the final bit of the byte marked `in_last`, the attempt fails. `rewind` pulses for one cycle, and a new `tgt_cfg_n` low pulse begins in that same cycle.
- R8: If `tgt_conf_done` is high at that point, exactly INIT_CLKS further shift-clock rising edges are issued, with `tgt_data` low.
- R9: `tgt_status_n` low at a clock edge while the loader is waiting for data, shifting, checking or initializing fails the attempt, with the same `rewind` and restart as R7.
- R10: After MAX_RETRY retries, the next failure raises `err`, drops `busy` and leaves `tgt_cfg_n` high. `err` stays set until the next `start`, which clears it.
- R11: While `done` or `err` is high, `tgt_dclk` and `tgt_data` are driven low.
- R12: With USE_INIT_DONE set, `done` rises only after `tgt_init_done` reads high following the initialization clocks. Without it, `done` rises directly after them. `done` clears when the next `start` is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a configuration run (single-cycle pulse) |
| half_div | input | DIV_W | Shift-clock half-period minus one, in clock cycles |
| in_data | input | 8 | Image byte |
| in_valid | input | 1 | Image byte is valid |
| in_last | input | 1 | Image byte is the final one |
| in_ready | output | 1 | Loader accepts a byte |
| tgt_cfg_n | output | 1 | Configuration request to device, active low |
| tgt_dclk | output | 1 | Shift clock to device |
| tgt_data | output | 1 | Serial data to device |
| tgt_status_n | input | 1 | Device status, low means reset or error |
| tgt_conf_done | input | 1 | Device reports all configuration data received |
| tgt_init_done | input | 1 | Device reports initialization finished |
| busy | output | 1 | A run is in progress |
| done | output | 1 | Last run ended with the device in user mode |
| err | output | 1 | Sticky: retries exhausted |
| rewind | output | 1 | One-cycle pulse: restart the image stream from its first byte |

## Verification
The request pulse is measured in whole clock cycles of low level, and must equal PULSE_CYC. Shift-clock phases are measured in clock cycles and must equal `half_div + 1`. `in_ready` falls in the cycle right after the accepting edge. A `rewind` and a new low request appear in the cycle after the failing condition is sampled. For a missing configuration-complete, that sampling falls one half-period after the last high phase ends. The bench drives inputs and samples outputs on falling clock edges. It records shift-clock edges, captured data bits and run lengths with monitors on every edge. It then compares totals and snapshots only after waiting well past the cycle each result is due, so a late or early response shows up as a wrong count, not as a timing race.

// File: rtl/ps_cfg_loader.sv
module ps_cfg_loader #(
  parameter int DIV_W         = 8,
  parameter int PULSE_CYC     = 8,
  parameter int INIT_CLKS     = 10,
  parameter int MAX_RETRY     = 3,
  parameter bit USE_INIT_DONE = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [DIV_W-1:0] half_div,
  input  logic [7:0]       in_data,
  input  logic             in_valid,
  input  logic             in_last,
  output logic             in_ready,
  output logic             tgt_cfg_n,
  output logic             tgt_dclk,
  output logic             tgt_data,
  input  logic             tgt_status_n,
  input  logic             tgt_conf_done,
  input  logic             tgt_init_done,
  output logic             busy,
  output logic             done,
  output logic             err,
  output logic             rewind
);
  localparam int PW = $clog2(PULSE_CYC + 1);
  localparam int IW = $clog2(INIT_CLKS + 1);
  localparam int RW = $clog2(MAX_RETRY + 2);

  typedef enum logic [3:0] {
    S_IDLE, S_PULSE, S_WAIT, S_LOAD, S_LO, S_HI,
    S_CHECK, S_ILO, S_IHI, S_UMODE, S_DONE, S_FAIL
  } st_t;

  st_t              st;
  logic [DIV_W-1:0] tcnt;
  logic [PW-1:0]    pcnt;
  logic [IW-1:0]    icnt;
  logic [RW-1:0]    tries;
  logic [2:0]       bidx;
  logic [7:0]       sh;
  logic             last_q;
  logic             rew;

  wire timed   = st inside {S_LO, S_HI, S_CHECK, S_ILO, S_IHI};
  wire watched = st inside {S_LOAD, S_LO, S_HI, S_CHECK, S_ILO, S_IHI, S_UMODE};
  wire tick    = tcnt == half_div;
  wire fail_now = (watched && !tgt_status_n) ||
                  (st == S_CHECK && tick && !tgt_conf_done);
  wire can_start = st inside {S_IDLE, S_DONE, S_FAIL};

  assign tgt_cfg_n = st != S_PULSE;
  assign tgt_dclk  = st == S_HI || st == S_IHI;
  assign tgt_data  = (st == S_LO || st == S_HI) && sh[0];
  assign in_ready  = st == S_LOAD && tgt_status_n;
  assign busy      = !can_start;
  assign done      = st == S_DONE;
  assign err       = st == S_FAIL;
  assign rewind    = rew;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      tcnt   <= '0;
      pcnt   <= '0;
      icnt   <= '0;
      tries  <= '0;
      bidx   <= '0;
      sh     <= '0;
      last_q <= 1'b0;
      rew    <= 1'b0;
    end else begin
      rew  <= 1'b0;
      tcnt <= (timed && !tick) ? tcnt + 1'b1 : '0;
      if (fail_now) begin
        if (tries == RW'(MAX_RETRY)) begin
          st <= S_FAIL;
        end else begin
          tries <= tries + 1'b1;
          rew   <= 1'b1;
          pcnt  <= '0;
          st    <= S_PULSE;
        end
      end else begin
        case (st)
          S_IDLE, S_DONE, S_FAIL:
            if (start) begin
              tries <= '0;
              pcnt  <= '0;
              st    <= S_PULSE;
            end
          S_PULSE: begin
            pcnt <= pcnt + 1'b1;
            if (pcnt == PW'(PULSE_CYC - 1)) st <= S_WAIT;
          end
          S_WAIT:
            if (tgt_status_n) st <= S_LOAD;
          S_LOAD:
            if (in_valid) begin
              sh     <= in_data;
              last_q <= in_last;
              bidx   <= '0;
              st     <= S_LO;
            end
          S_LO:
            if (tick) st <= S_HI;
          S_HI:
            if (tick) begin
              if (bidx == 3'd7) begin
                st <= last_q ? S_CHECK : S_LOAD;
              end else begin
                sh   <= sh >> 1;
                bidx <= bidx + 3'd1;
                st   <= S_LO;
              end
            end
          S_CHECK:
            if (tick) begin
              icnt <= '0;
              st   <= S_ILO;
            end
          S_ILO:
            if (tick) st <= S_IHI;
          S_IHI:
            if (tick) begin
              icnt <= icnt + 1'b1;
              if (icnt == IW'(INIT_CLKS - 1))
                st <= USE_INIT_DONE ? S_UMODE : S_DONE;
              else
                st <= S_ILO;
            end
          S_UMODE:
            if (tgt_init_done) st <= S_DONE;
          default: st <= S_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/ps_cfg_loader_chk.sv
module ps_cfg_loader_chk #(
  parameter bit USE_INIT_DONE = 1'b1
) (
  input logic clk,
  input logic rst_n,
  input logic in_valid,
  input logic in_ready,
  input logic tgt_cfg_n,
  input logic tgt_dclk,
  input logic tgt_data,
  input logic tgt_status_n,
  input logic tgt_init_done,
  input logic busy,
  input logic done,
  input logic err,
  input logic rewind
);
  a_r2_request_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !tgt_cfg_n |-> (!tgt_dclk && !in_ready && busy));

  a_r3_status_gate: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tgt_dclk) |-> $past(tgt_status_n));

  a_r4_data_held_high: assert property (@(posedge clk) disable iff (!rst_n)
    tgt_dclk |-> $stable(tgt_data));

  a_r6_ready_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);

  a_r7_rewind_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    rewind |-> (!tgt_cfg_n && busy));

  a_r10_err_idle: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (!busy && tgt_cfg_n && !done));

  a_r11_lines_parked: assert property (@(posedge clk) disable iff (!rst_n)
    (done || err) |-> (!tgt_dclk && !tgt_data));

  a_r12_user_mode: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(done) && USE_INIT_DONE) |-> $past(tgt_init_done));
endmodule

bind ps_cfg_loader ps_cfg_loader_chk #(.USE_INIT_DONE(USE_INIT_DONE)) chk_i (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .tgt_cfg_n(tgt_cfg_n), .tgt_dclk(tgt_dclk), .tgt_data(tgt_data),
  .tgt_status_n(tgt_status_n), .tgt_init_done(tgt_init_done),
  .busy(busy), .done(done), .err(err), .rewind(rewind)
);

// File: tb/ps_cfg_loader_tb_top.sv
module ps_cfg_loader_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DIV   = 2;
  localparam int PULSE = 4;
  localparam int INITC = 5;
  localparam int RETRY = 2;
  localparam int WD    = 150000;

  logic clk = 0, rst_n = 0, start = 0;
  logic [7:0] in_data = 0;
  logic in_valid = 0, in_last = 0, in_ready;
  logic tgt_cfg_n, tgt_dclk, tgt_data;
  logic tgt_status_n = 1, tgt_conf_done = 0, tgt_init_done = 0;
  logic busy, done, err, rewind;

  always #(CLK_PERIOD/2) clk = ~clk;

  ps_cfg_loader #(.DIV_W(8), .PULSE_CYC(PULSE), .INIT_CLKS(INITC),
                  .MAX_RETRY(RETRY), .USE_INIT_DONE(1'b1)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .half_div(8'(DIV)),
    .in_data(in_data), .in_valid(in_valid), .in_last(in_last), .in_ready(in_ready),
    .tgt_cfg_n(tgt_cfg_n), .tgt_dclk(tgt_dclk), .tgt_data(tgt_data),
    .tgt_status_n(tgt_status_n), .tgt_conf_done(tgt_conf_done),
    .tgt_init_done(tgt_init_done), .busy(busy), .done(done), .err(err),
    .rewind(rewind)
  );

  int checks = 0, fails = 0, cyc = 0;
  int edges = 0, npulse = 0, rewinds = 0;
  int lowrun = 0, last_low = 0, hirun = 0, last_hi = 0, dlorun = 0, last_dlo = 0;
  logic [31:0] cap = 0;

  always @(posedge tgt_dclk) begin
    cap   <= {tgt_data, cap[31:1]};
    edges <= edges + 1;
  end
  always @(negedge tgt_cfg_n) if (rst_n) npulse <= npulse + 1;

  always @(posedge clk) begin
    if (rewind) rewinds <= rewinds + 1;
    if (!tgt_cfg_n) lowrun <= lowrun + 1;
    else if (lowrun != 0) begin last_low <= lowrun; lowrun <= 0; end
    if (tgt_dclk) begin
      hirun <= hirun + 1;
      if (dlorun != 0) begin last_dlo <= dlorun; dlorun <= 0; end
    end else begin
      dlorun <= dlorun + 1;
      if (hirun != 0) begin last_hi <= hirun; hirun <= 0; end
    end
  end

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == WD) begin
      checks = checks + 1;
      fails  = fails + 1;
      $display("FAIL watchdog (all requirements): actual cycles=%0d expected <%0d", cyc, WD);
      summary();
      $finish;
    end
  end

  task automatic chk(input string tag, input bit ok, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic pulse_start();
    @(negedge clk) start = 1;
    @(negedge clk) start = 0;
  endtask

  task automatic send_byte(input logic [7:0] b, input logic lst);
    @(negedge clk);
    in_data = b; in_last = lst; in_valid = 1;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 0;
    chk("R6 ready low after accept", !in_ready, in_ready, 0);
  endtask

  task automatic wait_edges(input int n);
    for (int k = 0; k < 5000 && edges < n; k++) @(negedge clk);
  endtask

  task automatic wait_done();
    for (int k = 0; k < 5000 && !done; k++) @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1 reset outputs",
        tgt_cfg_n && !tgt_dclk && !tgt_data && !in_ready && !busy && !done && !err && !rewind,
        {tgt_cfg_n, tgt_dclk, tgt_data, in_ready, busy, done, err, rewind}, 8'b1000_0000);
  endtask

  task automatic t_normal();
    int e0, p0;
    logic [31:0] snap;
    tgt_status_n = 0; tgt_conf_done = 1; tgt_init_done = 0;
    e0 = edges; p0 = npulse;
    pulse_start();
    repeat (PULSE + 20) @(negedge clk);
    chk("R2 pulse width", last_low == PULSE, last_low, PULSE);
    chk("R2 one pulse", npulse - p0 == 1, npulse - p0, 1);
    chk("R3 gated on status", edges == e0 && !in_ready && busy, edges - e0, 0);
    @(negedge clk) start = 1;
    @(negedge clk) start = 0;
    chk("R2 start ignored while busy", npulse - p0 == 1 && tgt_cfg_n, npulse - p0, 1);
    tgt_status_n = 1;
    send_byte(8'hA5, 0);
    send_byte(8'h96, 1);
    wait_edges(e0 + 16);
    @(negedge clk);
    snap = cap;
    chk("R4 LSB-first data", snap[31:16] == 16'h96A5, snap[31:16], 16'h96A5);
    chk("R5 high phase", last_hi == DIV + 1, last_hi, DIV + 1);
    wait_edges(e0 + 16 + INITC);
    repeat (30) @(negedge clk);
    chk("R8 init clocks", edges - e0 == 16 + INITC, edges - e0, 16 + INITC);
    chk("R8 init data low", cap[31:32-INITC] == '0, cap[31:32-INITC], 0);
    chk("R5 low phase", last_dlo == DIV + 1, last_dlo, DIV + 1);
    chk("R12 waits for init done", !done && busy, done, 0);
    tgt_init_done = 1;
    repeat (3) @(negedge clk);
    chk("R12 done after init done", done && !busy && !err, done, 1);
    chk("R11 lines low when done", !tgt_dclk && !tgt_data, {tgt_dclk, tgt_data}, 0);
  endtask

  task automatic t_confdone();
    int r0, p0;
    tgt_status_n = 1; tgt_conf_done = 0; tgt_init_done = 1;
    r0 = rewinds; p0 = npulse;
    pulse_start();
    chk("R12 done cleared by start", !done, done, 0);
    send_byte(8'h5A, 1);
    for (int k = 0; k < 2000 && rewinds == r0; k++) @(negedge clk);
    chk("R7 request low on retry", !tgt_cfg_n, tgt_cfg_n, 0);
    chk("R7 one rewind", rewinds - r0 == 1, rewinds - r0, 1);
    tgt_conf_done = 1;
    send_byte(8'h5A, 1);
    wait_done();
    chk("R7 second attempt completes", done && npulse - p0 == 2, npulse - p0, 2);
  endtask

  task automatic t_status();
    int r0, e0;
    tgt_status_n = 1; tgt_conf_done = 1; tgt_init_done = 1;
    r0 = rewinds; e0 = edges;
    pulse_start();
    send_byte(8'hF0, 1);
    wait_edges(e0 + 3);
    tgt_status_n = 0;
    repeat (2) @(negedge clk);
    tgt_status_n = 1;
    @(negedge clk);
    chk("R9 status error restarts", rewinds - r0 == 1 && busy, rewinds - r0, 1);
    send_byte(8'hF0, 1);
    wait_done();
    chk("R9 recovers", done && !err, done, 1);
  endtask

  task automatic t_exhaust();
    int r0, p0;
    tgt_status_n = 1; tgt_conf_done = 0; tgt_init_done = 1;
    r0 = rewinds; p0 = npulse;
    pulse_start();
    for (int a = 0; a <= RETRY; a++) send_byte(8'hC3, 1);
    for (int k = 0; k < 2000 && busy; k++) @(negedge clk);
    repeat (2) @(negedge clk);
    chk("R10 err after retries", err && !busy && tgt_cfg_n, {err, busy, tgt_cfg_n}, 3'b101);
    chk("R10 retry count", rewinds - r0 == RETRY && npulse - p0 == RETRY + 1,
        rewinds - r0, RETRY);
    chk("R11 lines low on error", !tgt_dclk && !tgt_data, {tgt_dclk, tgt_data}, 0);
    repeat (10) @(negedge clk);
    chk("R10 err sticky", err, err, 1);
    pulse_start();
    chk("R10 start clears err", !err && busy, err, 0);
    tgt_conf_done = 1;
    send_byte(8'h11, 1);
    wait_done();
    chk("R10 run after error", done, done, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_normal();
    t_confdone();
    t_status();
    t_exhaust();
    repeat (5) @(negedge clk);
    summary();
    $finish;
  end
endmodule